// File: doc/BRIEF.md
# AHB-to-APB Bridge Control Sequencer

This block sits on an AHB bus as a slave and forwards every accepted upstream transfer to a slower APB-style peripheral bus. A single upstream transfer cannot finish in one cycle, because the downstream access has a command phase and an enable phase, and the peripheral may add any number of wait cycles. A four-state controller runs through idle, setup, access and completion for each transfer. While the downstream side works, the upstream master is held with wait states.

Upstream completion is tied strictly to the peripheral's ready signal. When the peripheral is done, the bridge hands back the captured read data, or reports the peripheral's error flag as a two-cycle AHB ERROR response. Transfers that are not real (IDLE or BUSY type, slave not selected, or the bus not ready) finish with zero wait states and never reach the peripheral. Each transfer is handled on its own: a new transfer is accepted only while the controller is idle.

Top module: `ahb_apb_bridge_ctl`

## Requirements
- R1: While rst_n is low and after its release, up_ready_out is 1, up_resp is 0, and dn_sel and dn_enable are 0.
- R2: A transfer is real when up_sel=1, up_ready_in=1 and up_trans is NONSEQ (2'b10) or SEQ (2'b11). In the idle state, a real transfer makes the next cycle a setup cycle. In that cycle dn_sel=1, dn_enable=0 and up_ready_out=0, and dn_addr and dn_write carry the address and direction that were sampled with the transfer.
- R3: A transfer with up_trans IDLE (2'b00) or BUSY (2'b01), or with up_sel=0, or with up_ready_in=0, starts no access. dn_sel stays 0, up_ready_out stays 1 and up_resp stays 0.
- R4: The setup state lasts exactly one cycle. It is always followed by an access cycle with dn_sel=1 and dn_enable=1.
- R5: The access state repeats while dn_ready is 0, and up_ready_out stays 0 through all setup and access cycles.
- R6: For a write, dn_wdata equals the up_wdata presented during the setup cycle. It holds that value through every access cycle.
- R7: In the cycle after an access cycle that sees dn_ready=1 with dn_err=0, up_ready_out is 1 for exactly one cycle and dn_sel and dn_enable are 0. After that, the block is idle again, with up_ready_out=1.
- R8: For a read, up_rdata in the completion cycle equals the dn_rdata present in the access cycle where dn_ready was 1. Data offered while dn_ready was 0 is never returned.
- R9: If dn_err=1 in the access cycle where dn_ready=1, the next cycle has up_resp=1 and up_ready_out=0. The cycle after that has up_resp=1 and up_ready_out=1. Then the block is idle, with up_resp=0 and up_ready_out=1.
- R10: A transfer that completes with dn_err=0 gives up_resp=0 in its completion cycle.
- R11: dn_addr and dn_write hold steady from the setup cycle through the last access cycle, even when the upstream address inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_sel | input | 1 | Slave select from the upstream decoder |
| up_addr | input | ADDR_W | Upstream address, address phase |
| up_trans | input | 2 | Upstream transfer type |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_wdata | input | DATA_W | Upstream write data, data phase |
| up_ready_in | input | 1 | Upstream bus ready |
| up_rdata | output | DATA_W | Read data returned upstream |
| up_ready_out | output | 1 | Slave ready, 0 inserts a wait state |
| up_resp | output | 1 | Response, 0 = OKAY, 1 = ERROR |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream direction |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_sel | output | 1 | Downstream select |
| dn_enable | output | 1 | Downstream enable phase |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_ready | input | 1 | Downstream completion |
| dn_err | input | 1 | Downstream error flag |

## Verification
In one access cycle, the peripheral's ready signal can arrive together with its error flag and with the read data. The bridge must then finish the access, capture the data and choose between the OKAY and two-cycle ERROR endings, all at the same clock edge. The sweep provokes this on every direction, with a ready on the very first access cycle and also after one to three waits, with the error flag both clear and set. During the waits, it offers deliberately wrong read data. Each transfer is judged by the exact cycle in which up_ready_out rises, the up_resp value in each of the closing cycles, and whether up_rdata equals the word present at the ready cycle rather than any earlier one.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } br_state_e;

    localparam logic [1:0] TR_IDLE = 2'b00;
    localparam logic [1:0] TR_BUSY = 2'b01;
    localparam logic [1:0] TR_NSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ  = 2'b11;

endpackage

// File: rtl/br_capture.sv
module br_capture
    import br_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_sel,
    input  logic [1:0]        up_trans,
    input  logic              up_ready_in,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_write,
    input  logic [DATA_W-1:0] up_wdata,
    input  br_state_e         state_q,
    output logic              is_real,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } cap_t;

    cap_t cap_d, cap_q;

    // A transfer counts only when selected, the bus is ready and it is a
    // non-sequential or sequential type.
    always_comb begin
        is_real = up_sel && up_ready_in &&
                  ((up_trans == TR_NSEQ) || (up_trans == TR_SEQ));
    end

    always_comb begin
        cap_d = cap_q;
        if ((state_q == ST_IDLE) && is_real) begin
            cap_d.addr  = up_addr;
            cap_d.write = up_write;
        end
        // Data phase lines up with the setup cycle.
        if ((state_q == ST_SETUP) && cap_q.write) begin
            cap_d.wdata = up_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_q  = cap_q.addr;
    assign write_q = cap_q.write;
    assign wdata_q = cap_q.wdata;

endmodule

// File: rtl/br_seq.sv
module br_seq
    import br_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      dn_ready,
    input  logic      dn_err,
    output br_state_e state_q,
    output logic      err_first_q
);

    typedef struct packed {
        br_state_e state;
        logic      err_first;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                seq_d.state = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (dn_ready) begin
                    seq_d.state     = ST_DONE;
                    seq_d.err_first = dn_err;
                end
            end
            ST_DONE: begin
                if (seq_q.err_first) begin
                    // first half of the error response: stay one more cycle
                    seq_d.err_first = 1'b0;
                end else begin
                    seq_d.state = ST_IDLE;
                end
            end
            default: begin
                seq_d.state     = ST_IDLE;
                seq_d.err_first = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state     <= ST_IDLE;
            seq_q.err_first <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_q     = seq_q.state;
    assign err_first_q = seq_q.err_first;

endmodule

// File: rtl/br_result.sv
module br_result
    import br_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  br_state_e         state_q,
    input  logic              err_first_q,
    input  logic              write_q,
    input  logic              dn_ready,
    input  logic              dn_err,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_ready_out,
    output logic              up_resp
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if ((state_q == ST_ACCESS) && dn_ready) begin
            res_d.rdata = dn_rdata;
            res_d.err   = dn_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        up_ready_out = (state_q == ST_IDLE) ||
                       ((state_q == ST_DONE) && !err_first_q);
        up_resp      = (state_q == ST_DONE) && res_q.err;
        up_rdata     = ((state_q == ST_DONE) && !write_q) ? res_q.rdata : '0;
    end

endmodule

// File: rtl/ahb_apb_bridge_ctl.sv
module ahb_apb_bridge_ctl
    import br_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_sel,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [1:0]        up_trans,
    input  logic              up_write,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic              up_ready_in,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_ready_out,
    output logic              up_resp,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    output logic              dn_sel,
    output logic              dn_enable,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_ready,
    input  logic              dn_err
);

    br_state_e         state_q;
    logic              err_first_q;
    logic              is_real;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    br_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_sel      (up_sel),
        .up_trans    (up_trans),
        .up_ready_in (up_ready_in),
        .up_addr     (up_addr),
        .up_write    (up_write),
        .up_wdata    (up_wdata),
        .state_q     (state_q),
        .is_real     (is_real),
        .addr_q      (addr_q),
        .write_q     (write_q),
        .wdata_q     (wdata_q)
    );

    br_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (is_real),
        .dn_ready    (dn_ready),
        .dn_err      (dn_err),
        .state_q     (state_q),
        .err_first_q (err_first_q)
    );

    br_result #(.DATA_W(DATA_W)) i_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .err_first_q  (err_first_q),
        .write_q      (write_q),
        .dn_ready     (dn_ready),
        .dn_err       (dn_err),
        .dn_rdata     (dn_rdata),
        .up_rdata     (up_rdata),
        .up_ready_out (up_ready_out),
        .up_resp      (up_resp)
    );

    always_comb begin
        dn_sel    = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        dn_enable = (state_q == ST_ACCESS);
        dn_addr   = addr_q;
        dn_write  = write_q;
        // setup cycle forwards the data phase directly; later cycles hold it
        dn_wdata  = (state_q == ST_SETUP) ? up_wdata : wdata_q;
    end

endmodule

// File: rtl/br_checker.sv
module br_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_ready_out,
    input logic              up_resp,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              dn_write,
    input logic [DATA_W-1:0] dn_wdata,
    input logic              dn_sel,
    input logic              dn_enable,
    input logic              dn_ready
);

    // R4: setup is followed by an access cycle
    a_r4_setup_then_access: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && !dn_enable) |=> (dn_sel && dn_enable));

    // R5: access repeats while the peripheral is not ready
    a_r5_access_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_enable && !dn_ready) |=> (dn_sel && dn_enable));

    // R5: master held whenever the downstream is busy
    a_r5_master_held: assert property (@(posedge clk) disable iff (!rst_n)
        dn_sel |-> !up_ready_out);

    // R7: release from an access only after downstream ready
    a_r7_release_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (up_ready_out && $past(dn_enable)) |-> $past(dn_ready));

    // R9: first error cycle is followed by the releasing error cycle
    a_r9_error_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (up_resp && !up_ready_out) |=> (up_resp && up_ready_out));

    // R11: downstream address and direction stable through the access
    a_r11_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_sel && $past(dn_sel)) |-> ($stable(dn_addr) && $stable(dn_write)));

    // R6: write data held across access cycles
    a_r6_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_enable && $past(dn_enable)) |-> $stable(dn_wdata));

endmodule

bind ahb_apb_bridge_ctl br_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_br_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_ready_out (up_ready_out),
    .up_resp      (up_resp),
    .dn_addr      (dn_addr),
    .dn_write     (dn_write),
    .dn_wdata     (dn_wdata),
    .dn_sel       (dn_sel),
    .dn_enable    (dn_enable),
    .dn_ready     (dn_ready)
);

// File: tb/test_ahb_apb_bridge_ctl.sv
module test_ahb_apb_bridge_ctl;

    localparam int  ADDR_W   = 16;
    localparam int  DATA_W   = 32;
    localparam time CLK_HALF = 5ns;
    localparam int  WDOG_MAX = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              up_sel = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [1:0]        up_trans = 2'b00;
    logic              up_write = 1'b0;
    logic [DATA_W-1:0] up_wdata = '0;
    logic              up_ready_in = 1'b1;
    logic [DATA_W-1:0] up_rdata;
    logic              up_ready_out;
    logic              up_resp;
    logic [ADDR_W-1:0] dn_addr;
    logic              dn_write;
    logic [DATA_W-1:0] dn_wdata;
    logic              dn_sel;
    logic              dn_enable;
    logic [DATA_W-1:0] dn_rdata = '0;
    logic              dn_ready = 1'b0;
    logic              dn_err = 1'b0;

    int vectors = 0;
    int errs    = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    ahb_apb_bridge_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ahb_apb_bridge_ctl (
        .clk(clk), .rst_n(rst_n),
        .up_sel(up_sel), .up_addr(up_addr), .up_trans(up_trans),
        .up_write(up_write), .up_wdata(up_wdata), .up_ready_in(up_ready_in),
        .up_rdata(up_rdata), .up_ready_out(up_ready_out), .up_resp(up_resp),
        .dn_addr(dn_addr), .dn_write(dn_write), .dn_wdata(dn_wdata),
        .dn_sel(dn_sel), .dn_enable(dn_enable),
        .dn_rdata(dn_rdata), .dn_ready(dn_ready), .dn_err(dn_err)
    );

    always #(CLK_HALF) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_MAX && !done) begin
                errs++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG_MAX);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
                $finish;
            end
        end
    end

    // smode: 0 selected and ready, 1 not selected, 2 bus not ready
    task automatic xfer(input int t, input bit w, input int waits, input bit err,
                        input int smode, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] rd);
        bit real_x;
        real_x = (smode == 0) && (t >= 2);
        @(negedge clk);
        up_sel      = (smode != 1);
        up_ready_in = (smode != 2);
        up_trans    = t[1:0];
        up_write    = w;
        up_addr     = a;
        #1;
        chk("R1/R7 idle ready", 32'(up_ready_out), 32'd1);
        @(negedge clk);
        up_sel = 1'b0; up_trans = 2'b00; up_ready_in = 1'b1;
        up_addr = ~a; up_write = ~w; up_wdata = wd;
        #1;
        if (!real_x) begin
            chk("R3 no select", 32'(dn_sel), 32'd0);
            chk("R3 ready stays", 32'(up_ready_out), 32'd1);
            chk("R3 resp okay", 32'(up_resp), 32'd0);
            return;
        end
        chk("R2 setup sel", 32'(dn_sel), 32'd1);
        chk("R2 setup enable", 32'(dn_enable), 32'd0);
        chk("R2 setup wait", 32'(up_ready_out), 32'd0);
        chk("R2 addr", 32'(dn_addr), 32'(a));
        chk("R2 dir", 32'(dn_write), 32'(w));
        if (w) chk("R6 setup wdata", dn_wdata, wd);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            dn_ready = (i == waits);
            dn_err   = (i == waits) ? err : ~err;
            dn_rdata = (i == waits) ? rd : ~rd;
            #1;
            chk("R4 access sel", 32'(dn_sel), 32'd1);
            chk("R4 access enable", 32'(dn_enable), 32'd1);
            chk("R5 held", 32'(up_ready_out), 32'd0);
            chk("R11 addr stable", 32'(dn_addr), 32'(a));
            chk("R11 dir stable", 32'(dn_write), 32'(w));
            if (w) chk("R6 access wdata", dn_wdata, wd);
        end
        @(negedge clk);
        dn_ready = 1'b0; dn_err = 1'b1; dn_rdata = ~rd;
        #1;
        chk("R7 sel off", 32'(dn_sel), 32'd0);
        chk("R7 enable off", 32'(dn_enable), 32'd0);
        if (!err) begin
            chk("R7 release", 32'(up_ready_out), 32'd1);
            chk("R10 okay", 32'(up_resp), 32'd0);
            if (!w) chk("R8 rdata", up_rdata, rd);
        end else begin
            chk("R9 err first ready", 32'(up_ready_out), 32'd0);
            chk("R9 err first resp", 32'(up_resp), 32'd1);
            @(negedge clk);
            #1;
            chk("R9 err second ready", 32'(up_ready_out), 32'd1);
            chk("R9 err second resp", 32'(up_resp), 32'd1);
        end
        @(negedge clk);
        dn_err = 1'b0;
        #1;
        chk("R7 back idle ready", 32'(up_ready_out), 32'd1);
        chk("R7 back idle resp", 32'(up_resp), 32'd0);
        chk("R7 back idle sel", 32'(dn_sel), 32'd0);
    endtask

    initial begin
        int n;
        n = 0;
        #1;
        chk("R1 reset ready", 32'(up_ready_out), 32'd1);
        chk("R1 reset resp", 32'(up_resp), 32'd0);
        chk("R1 reset sel", 32'(dn_sel), 32'd0);
        chk("R1 reset enable", 32'(dn_enable), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after reset ready", 32'(up_ready_out), 32'd1);
        chk("R1 after reset sel", 32'(dn_sel), 32'd0);
        for (int sm = 0; sm < 3; sm++) begin
            for (int t = 0; t < 4; t++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int wt = 0; wt < 4; wt++) begin
                        for (int e = 0; e < 2; e++) begin
                            for (int k = 0; k < 2; k++) begin
                                n++;
                                xfer(t, w[0], wt, e[0], sm,
                                     16'(n * 16'h1357 + k * 16'h8001),
                                     32'(n * 32'h0101_0F0B) ^ 32'hA5A5_0000,
                                     32'(n * 32'h0003_C1D7) ^ 32'h5A00_00FF);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule